// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregator

The block watches seventeen sensor interrupt lines, brings each one into the system clock domain, and notices every level change. When any line moves, it takes a snapshot of all line levels. The snapshot is pushed to the host CPU over a dedicated serial link on which this block is the master. The host therefore never polls for interrupt state: a fixed-length frame arrives a few cycles after the pin change, and a one-cycle request pulse lets a DMA engine collect it.

Storage is split into a transmit shift register and one pending snapshot. A change that arrives while a frame is on the wire is held and sent right after that frame. If the pending slot is already occupied when yet another change arrives, the pending snapshot is refreshed to the newest levels and marked as merged. No change is silently discarded, and the host can tell that intermediate states were folded together.

Top module: `irq_aggregator`

## Requirements
- R1: Each line passes through a two-flop synchronizer. A level change on `irq_i` driven just after a clock edge makes `cs_no` go low at the fourth following rising edge, and not before.
- R2: A frame is 24 bits sent MSB first. Bits 23..7 carry the synchronized levels of lines 16..0 at capture time, bit 6 is the merge flag, and bits 5..0 are zero.
- R3: The link runs in SPI mode 0. `sclk_o` toggles at half the system clock and is low whenever `cs_no` is high. `mosi_o` changes only while `sclk_o` is low. `cs_no` stays low for exactly 48 system clock cycles per frame.
- R4: `dma_req_o` is a single-cycle pulse asserted in the first cycle `cs_no` is high after a frame, and at no other time.
- R5: A change that arrives while a frame is being sent is kept in the pending slot with merge flag 0. It is sent as the next frame, with `cs_no` high for exactly one cycle between the two frames.
- R6: A further change that arrives while both the transmitter and the pending slot are occupied does not start an extra frame. It replaces the pending levels with the newest ones and sets the merge flag to 1.
- R7: While all lines hold steady, no frame is sent.
- R8: During and right after reset, `cs_no` is high, and `sclk_o`, `mosi_o` and `dma_req_o` are low. The level baseline after reset is all lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 17 | Asynchronous sensor interrupt lines |
| sclk_o | output | 1 | Serial clock to host, system clock / 2, idle low |
| cs_no | output | 1 | Frame select to host, active low |
| mosi_o | output | 1 | Serial data to host, MSB first |
| dma_req_o | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The hardest state to reach is the pending slot being full while a frame is still shifting, because a third change has to land inside a 48-cycle window that opens only after the synchronizer and capture delays. Directed stimulus times three changes at fixed offsets from the first one, so the second lands after the first frame has started and the third lands before that frame ends. Constrained random toggles, spaced wider than a frame, then cover many distinct level patterns one frame at a time.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned LINES_DEF   = 17;
  localparam int unsigned FRAME_W_DEF = 24;
  localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 17,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned WIDTH = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic             take_i,
  output logic             pend_valid_o,
  output logic [WIDTH-1:0] pend_lvl_o,
  output logic             pend_merged_o
);
  logic [WIDTH-1:0] prev_q;
  logic             change;

  assign change = |(lvl_i ^ prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q        <= '0;
      pend_valid_o  <= 1'b0;
      pend_lvl_o    <= '0;
      pend_merged_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (take_i) begin
        // slot drains this cycle; a simultaneous change refills it cleanly
        pend_valid_o  <= change;
        pend_merged_o <= 1'b0;
        if (change) pend_lvl_o <= lvl_i;
      end else if (change) begin
        pend_lvl_o    <= lvl_i;
        pend_valid_o  <= 1'b1;
        pend_merged_o <= pend_valid_o;
      end
    end
  end
endmodule

// File: rtl/spi_frame_tx.sv
module spi_frame_tx #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ready_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  output logic               done_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               busy_q, phase_q;
  logic [CNT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      shift_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (load_i) begin
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          bit_q   <= '0;
          shift_q <= frame_i;
        end
      end else if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        // falling edge of sclk: advance data or close the frame
        phase_q <= 1'b0;
        if (bit_q == LAST_BIT) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          bit_q   <= bit_q + 1'b1;
          shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign ready_o = !busy_q;
  assign cs_no   = !busy_q;
  assign sclk_o  = busy_q & phase_q;
  assign mosi_o  = busy_q & shift_q[FRAME_W-1];
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_LINES     = LINES_DEF,
  parameter int unsigned FRAME_W     = FRAME_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  output logic               dma_req_o
);
  localparam int unsigned FLAG_POS = FRAME_W - N_LINES - 1;

  logic [N_LINES-1:0] lvl;
  logic [N_LINES-1:0] pend_lvl;
  logic               pend_valid, pend_merged;
  logic               tx_ready, take;
  logic [FRAME_W-1:0] frame;

  irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (lvl)
  );

  irq_capture #(.WIDTH(N_LINES)) u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lvl_i        (lvl),
    .take_i       (take),
    .pend_valid_o (pend_valid),
    .pend_lvl_o   (pend_lvl),
    .pend_merged_o(pend_merged)
  );

  assign take = pend_valid & tx_ready;

  always_comb begin
    frame = '0;
    frame[FRAME_W-1 -: N_LINES] = pend_lvl;
    frame[FLAG_POS]             = pend_merged;
  end

  spi_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .frame_i(frame),
    .ready_o(tx_ready),
    .sclk_o (sclk_o),
    .cs_no  (cs_no),
    .mosi_o (mosi_o),
    .done_o (dma_req_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned FRAME_W = 24
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o,
  input logic dma_req_o,
  input logic pend_valid_i,
  input logic take_i
);
  logic [15:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_cnt_q <= '0;
    else if (!cs_no) low_cnt_q <= low_cnt_q + 1'b1;
    else            low_cnt_q <= '0;
  end

  assert_idle_clock_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_mosi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o) |-> $stable(mosi_o));

  assert_frame_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (low_cnt_q == 16'(2 * FRAME_W)));

  assert_req_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o);

  assert_req_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (cs_no && !$past(cs_no)));

  assert_pend_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && !take_i) |=> pend_valid_i);
endmodule

bind irq_aggregator irq_aggregator_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_o      (sclk_o),
  .cs_no       (cs_no),
  .mosi_o      (mosi_o),
  .dma_req_o   (dma_req_o),
  .pend_valid_i(pend_valid),
  .take_i      (take)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [16:0] irq_i = '0;
  logic        sclk_o, cs_no, mosi_o, dma_req_o;

  int checks = 0, errors = 0;
  bit fin = 1'b0;
  int nb = 0, lowc = 0, hi_run = 0;
  logic [23:0] sh = '0;
  logic [23:0] frm_q[$];
  int          gap_q[$];

  always #5 clk_i = ~clk_i;

  irq_aggregator dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .sclk_o   (sclk_o),
    .cs_no    (cs_no),
    .mosi_o   (mosi_o),
    .dma_req_o(dma_req_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [16:0] l, input logic m);
    return {l, m, 6'b0};
  endfunction

  // frame monitor, samples on the falling clock edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      nb = 0; lowc = 0; hi_run = 0;
    end else if (!cs_no) begin
      if (lowc == 0) gap_q.push_back(hi_run);
      hi_run = 0;
      lowc++;
      if (sclk_o) begin
        sh = {sh[22:0], mosi_o};
        nb++;
      end
      if (dma_req_o) chk(1'b0, "R4 request while selected", 1, 0);
    end else begin
      if (sclk_o) chk(1'b0, "R3 sclk high while idle", 1, 0);
      if (lowc > 0) begin
        frm_q.push_back(sh);
        chk(nb == 24, "R2 bits per frame", nb, 24);
        chk(lowc == 48, "R3 select low cycles", lowc, 48);
        chk(dma_req_o == 1'b1, "R4 request at frame end", dma_req_o, 1);
      end else if (dma_req_o) begin
        chk(1'b0, "R4 stray request", 1, 0);
      end
      nb = 0; lowc = 0; hi_run++;
    end
  end

  task automatic set_lines(input logic [16:0] v);
    @(negedge clk_i);
    irq_i = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int base;
    logic [16:0] lv;
    void'($urandom(32'd20240611));
    idle(3);
    chk(cs_no == 1'b1, "R8 reset cs", cs_no, 1);
    chk(sclk_o == 1'b0, "R8 reset sclk", sclk_o, 0);
    chk(mosi_o == 1'b0, "R8 reset mosi", mosi_o, 0);
    chk(dma_req_o == 1'b0, "R8 reset req", dma_req_o, 0);
    rst_ni = 1'b1;
    idle(20);
    chk(frm_q.size() == 0, "R7 no frame after reset with low lines", frm_q.size(), 0);

    // R1 latency through synchronizer and capture
    set_lines(17'h00001);
    idle(3);
    chk(cs_no == 1'b1, "R1 select not early", cs_no, 1);
    idle(1);
    chk(cs_no == 1'b0, "R1 select at fourth edge", cs_no, 0);
    idle(100);
    chk(frm_q.size() == 1, "R1 one frame", frm_q.size(), 1);
    chk(frm_q[0] == mk(17'h00001, 1'b0), "R2 single change frame", frm_q[0], mk(17'h00001, 1'b0));

    // R2 all lines high, then all low
    base = frm_q.size();
    set_lines(17'h1FFFF); idle(100);
    set_lines(17'h00000); idle(100);
    chk(frm_q.size() == base + 2, "R2 frame count all-high/low", frm_q.size(), base + 2);
    chk(frm_q[base] == mk(17'h1FFFF, 1'b0), "R2 all lines high", frm_q[base], mk(17'h1FFFF, 1'b0));
    chk(frm_q[base+1] == mk(17'h00000, 1'b0), "R2 all lines low", frm_q[base+1], mk(17'h00000, 1'b0));

    // R5 change during transmission is held and sent next, one-cycle gap
    base = frm_q.size();
    set_lines(17'h00001); idle(10);
    set_lines(17'h10001); idle(150);
    chk(frm_q.size() == base + 2, "R5 two frames", frm_q.size(), base + 2);
    chk(frm_q[base] == mk(17'h00001, 1'b0), "R5 first frame", frm_q[base], mk(17'h00001, 1'b0));
    chk(frm_q[base+1] == mk(17'h10001, 1'b0), "R5 held frame", frm_q[base+1], mk(17'h10001, 1'b0));
    chk(gap_q[base+1] == 1, "R5 one-cycle gap", gap_q[base+1], 1);

    // R6 third change while both buffers occupied merges into pending slot
    base = frm_q.size();
    set_lines(17'h10000); idle(10);
    set_lines(17'h10020); idle(10);
    set_lines(17'h00020); idle(150);
    chk(frm_q.size() == base + 2, "R6 no extra frame", frm_q.size(), base + 2);
    chk(frm_q[base] == mk(17'h10000, 1'b0), "R6 first frame", frm_q[base], mk(17'h10000, 1'b0));
    chk(frm_q[base+1] == mk(17'h00020, 1'b1), "R6 merged frame", frm_q[base+1], mk(17'h00020, 1'b1));

    // R1/R2 random patterns, one change per frame window
    lv = 17'h00020;
    for (int i = 0; i < 24; i++) begin
      logic [16:0] msk;
      msk = 17'($urandom());
      if (msk == '0) msk = 17'h00100;
      lv  = lv ^ msk;
      base = frm_q.size();
      set_lines(lv);
      idle(60 + int'($urandom_range(0, 15)));
      chk(frm_q.size() == base + 1, "R1 random one frame", frm_q.size(), base + 1);
      if (frm_q.size() == base + 1)
        chk(frm_q[base] == mk(lv, 1'b0), "R2 random frame", frm_q[base], mk(lv, 1'b0));
    end

    // R7 steady lines send nothing
    base = frm_q.size();
    idle(300);
    chk(frm_q.size() == base, "R7 quiet lines", frm_q.size(), base);
    chk(cs_no == 1'b1, "R7 select idle", cs_no, 1);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule